// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block connects a synchronous host to an external asynchronous static RAM with a 19-bit address and an 8-bit data bus. The host starts an access with a single-cycle request while `ready` is high. The controller then registers the address and the write data and holds them on the memory pins for the whole access. It drives the two chip selects, the output enable and the write enable for whole numbers of clock cycles, and it returns read data when `ready` comes back.

Every strobe phase is found by ceiling division of a nanosecond minimum by `CLK_PERIOD_NS`. At the default 5 ns clock:

* A read holds output enable low for 14 cycles, which covers the 70 ns address access time, the 35 ns output-enable access time and the 70 ns read cycle.
* A write holds write enable low for 13 cycles, which covers the 55 ns pulse width, the 60 ns select-to-end and address-to-end times, the 30 ns data setup time, and the 70 ns write cycle together with one extra hold cycle.
* After a read, the controller waits 5 cycles before `ready` returns. This lets the memory outputs float, which can take up to 25 ns, before the controller may drive the data bus.

The data bus is split into an output, an input and a drive enable, so that a pad ring can build the tri-state buffer.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst_n` is low: `mem_cs_n` = 1, `mem_cs` = 0, `mem_oe_n` = 1, `mem_we_n` = 1, `dq_oe` = 0 and `ready` = 1.
- R2: Whenever `ready` is high, the memory is deselected (`mem_cs_n` = 1, `mem_cs` = 0), `mem_oe_n` and `mem_we_n` are high, and `dq_oe` is 0.
- R3: A read keeps the memory selected with `mem_oe_n` low and `mem_we_n` high for ceil(max(70, 35, 70) / CLK_PERIOD_NS) cycles (14 at 5 ns). `rdata` takes the value on `dq_i` at the end of that window.
- R4: `ready` comes back RD + TA cycles after a read is accepted (19 at 5 ns) and WR + 1 cycles after a write is accepted (14 at 5 ns). `rdata` is valid when `ready` comes back after a read.
- R5: A write keeps the memory selected, with `mem_oe_n` high and `dq_oe` high, and holds `mem_we_n` low for max(ceil(max(55, 60, 60, 30) / CLK_PERIOD_NS), ceil(70 / CLK_PERIOD_NS) - 1) cycles (13 at 5 ns). The memory therefore sees a pulse of at least 55 ns, at least 60 ns of select and address before the pulse ends, and at least 30 ns of stable data.
- R6: `mem_we_n` rises one cycle before `dq_oe` falls. During that cycle the chip selects stay active and `dq_o` keeps the write data.
- R7: `mem_addr` and `dq_o` keep the values registered at acceptance for the whole access, even when the host `addr` and `wdata` inputs change.
- R8: `dq_oe` does not rise until at least ceil(25 / CLK_PERIOD_NS) cycles (5 at 5 ns) after `mem_oe_n` last rose, so the controller never drives the bus while the memory may still be driving it.
- R9: `req` has no effect while `ready` is low. No access is started and the running access is neither lengthened nor altered.
- R10: `mem_oe_n` and `mem_we_n` are never low together, and `dq_oe` is never high while `mem_oe_n` is low.
- R11: A request with `ready` high is accepted at that clock edge, and `ready` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request, accepted when `ready` is high |
| wr | input | 1 | 1 = write, 0 = read, sampled with `req` |
| addr | input | 19 | Host address |
| wdata | input | 8 | Host write data |
| ready | output | 1 | Controller idle and able to accept a request |
| rdata | output | 8 | Data from the last read |
| mem_addr | output | 19 | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_cs | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| dq_o | output | 8 | Data driven toward the memory |
| dq_oe | output | 1 | Drive enable for `dq_o` |
| dq_i | input | 8 | Data bus as seen from the memory |

## Verification
A cycle counter that reloads with the wrong value shows up within a single access, as a strobe that is one or more cycles too short or too long on `mem_oe_n` or `mem_we_n`. In a read, a strobe that is too short also shows as data sampled before the memory model presents valid data, so `rdata` is wrong when `ready` returns. A state register that skips the turnaround or the hold phase shows in the very next access, as bus contention or as `dq_oe` and `mem_we_n` releasing in the same cycle. A state that never returns to idle shows as `ready` staying low.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int CLK_PERIOD_NS = 5,
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int T_RC_NS       = 70,
  parameter int T_AA_NS       = 70,
  parameter int T_OE_NS       = 35,
  parameter int T_WC_NS       = 70,
  parameter int T_WP_NS       = 55,
  parameter int T_CW_NS       = 60,
  parameter int T_AW_NS       = 60,
  parameter int T_DW_NS       = 30,
  parameter int T_HZ_NS       = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_i
);

  function automatic int cdiv(input int ns);
    return (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC = cdiv(imax(imax(T_AA_NS, T_OE_NS), T_RC_NS));
  localparam int WP_CYC = imax(cdiv(imax(imax(T_WP_NS, T_CW_NS), imax(T_AW_NS, T_DW_NS))),
                               cdiv(T_WC_NS) - 1);
  localparam int TA_CYC = imax(cdiv(T_HZ_NS), 1);
  localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), TA_CYC);
  localparam int CNT_W  = $clog2(MAX_CYC + 1);

  if (CLK_PERIOD_NS < 1 || RD_CYC < 1 || WP_CYC < 1 || TA_CYC < 1) begin : g_bad_timing
    $error("sram_async_ctrl: strobe cycle count below one");
  end

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RTA, S_WR, S_WEND} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               last;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (req) begin
          addr_q  <= addr;
          wdata_q <= wdata;
          if (wr) begin
            state <= S_WR;
            cnt   <= CNT_W'(WP_CYC - 1);
          end else begin
            state <= S_RD;
            cnt   <= CNT_W'(RD_CYC - 1);
          end
        end
        S_RD: if (last) begin
          rdata <= dq_i;
          state <= S_RTA;
          cnt   <= CNT_W'(TA_CYC - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_RTA: if (last) state <= S_IDLE;
               else      cnt   <= cnt - 1'b1;
        S_WR: if (last) state <= S_WEND;
              else      cnt   <= cnt - 1'b1;
        S_WEND: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic selected;
  assign selected = (state == S_RD) || (state == S_WR) || (state == S_WEND);

  assign ready    = (state == S_IDLE);
  assign mem_addr = addr_q;
  assign mem_cs_n = !selected;
  assign mem_cs   = selected;
  assign mem_oe_n = (state != S_RD);
  assign mem_we_n = (state != S_WR);
  assign dq_o     = wdata_q;
  assign dq_oe    = (state == S_WR) || (state == S_WEND);

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int CLK_PERIOD_NS = 5,
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int T_RC_NS       = 70,
  parameter int T_AA_NS       = 70,
  parameter int T_OE_NS       = 35,
  parameter int T_WC_NS       = 70,
  parameter int T_WP_NS       = 55,
  parameter int T_CW_NS       = 60,
  parameter int T_AW_NS       = 60,
  parameter int T_DW_NS       = 30,
  parameter int T_HZ_NS       = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_cs,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe
);

  function automatic int cdiv(input int ns);
    return (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC = cdiv(imax(imax(T_AA_NS, T_OE_NS), T_RC_NS));
  localparam int WP_CYC = imax(cdiv(imax(imax(T_WP_NS, T_CW_NS), imax(T_AW_NS, T_DW_NS))),
                               cdiv(T_WC_NS) - 1);
  localparam int TA_CYC = imax(cdiv(T_HZ_NS), 1);

  logic [15:0] oe_lo_cnt, we_lo_cnt, oe_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_lo_cnt <= '0;
      we_lo_cnt <= '0;
      oe_hi_cnt <= 16'hFFFF;
    end else begin
      oe_lo_cnt <= mem_oe_n ? 16'd0 : oe_lo_cnt + ((oe_lo_cnt != 16'hFFFF) ? 16'd1 : 16'd0);
      we_lo_cnt <= mem_we_n ? 16'd0 : we_lo_cnt + ((we_lo_cnt != 16'hFFFF) ? 16'd1 : 16'd0);
      oe_hi_cnt <= !mem_oe_n ? 16'd0 : oe_hi_cnt + ((oe_hi_cnt != 16'hFFFF) ? 16'd1 : 16'd0);
    end
  end

  assert_idle_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !dq_oe));

  assert_read_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_lo_cnt >= 16'(RD_CYC)));

  assert_write_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt >= 16'(WP_CYC)));

  assert_write_context_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (dq_oe && !mem_cs_n && mem_cs && mem_oe_n));

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> ($past(mem_we_n) && $past(!mem_cs_n)));

  assert_pins_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready)) |-> ($stable(mem_addr) && $stable(dq_o)));

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (oe_hi_cnt >= 16'(TA_CYC)));

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_no_drive_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && !mem_oe_n));

  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req) |=> !ready);

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .T_RC_NS(T_RC_NS), .T_AA_NS(T_AA_NS), .T_OE_NS(T_OE_NS), .T_WC_NS(T_WC_NS),
  .T_WP_NS(T_WP_NS), .T_CW_NS(T_CW_NS), .T_AW_NS(T_AW_NS), .T_DW_NS(T_DW_NS),
  .T_HZ_NS(T_HZ_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .mem_addr(mem_addr),
  .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .dq_o(dq_o), .dq_oe(dq_oe)
);

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;

  localparam int P      = 5;
  localparam int EXP_RD = (70 + P - 1) / P;
  localparam int EXP_WP = 13;
  localparam int EXP_TA = (25 + P - 1) / P;

  logic clk = 0, rst_n = 0, req = 0, wr = 0;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic ready, mem_cs_n, mem_cs, mem_oe_n, mem_we_n, dq_oe;
  logic [7:0]  rdata, dq_o, dq_i;
  logic [18:0] mem_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sram_async_ctrl #(.CLK_PERIOD_NS(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .dq_o(dq_o),
    .dq_oe(dq_oe), .dq_i(dq_i));

  task automatic chk(input bit ok, input string rq, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] seed_val(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A;
  endfunction

  // memory model
  logic [7:0] mem [int];
  logic [7:0] shadow [int];
  logic       mdrv = 0;
  logic [7:0] mval = '0;

  function automatic logic [7:0] mem_rd(input logic [18:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : seed_val(a);
  endfunction

  function automatic logic [7:0] shadow_rd(input logic [18:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : seed_val(a);
  endfunction

  assign dq_i = dq_oe ? dq_o : (mdrv ? mval : 8'h00);

  int tnow = 0, rd_start = 0, rd_end = -1000, wr_start = 0, cs_start = 0;
  int data_since = 0, addr_since = 0;
  bit p_sel = 0, p_rmode = 0, p_wact = 0;
  logic [18:0] p_addr = '0, wr_addr = '0;
  logic [7:0]  p_dq = '0;

  task automatic tick();
    bit sel, rmode, wact;
    sel   = !mem_cs_n && mem_cs;
    rmode = sel && !mem_oe_n && mem_we_n;
    wact  = sel && !mem_we_n;
    if (sel && !p_sel) cs_start = tnow;
    if (mem_addr != p_addr) addr_since = tnow;
    if (rmode && (!p_rmode || mem_addr != p_addr)) rd_start = tnow;
    if (!rmode && p_rmode) rd_end = tnow;
    mdrv = rmode || (tnow - rd_end < 25);
    // one tick of tolerance for the 1 ns sampling grid
    mval = (rmode && (tnow - rd_start >= 69)) ? mem_rd(mem_addr) : ~mem_rd(mem_addr);
    if (dq_oe && mdrv) chk(0, "R8", 1, 0, "bus contention");
    if (!dq_oe || dq_o != p_dq) data_since = tnow;
    if (wact && !p_wact) begin wr_start = tnow; wr_addr = mem_addr; end
    if (wact && p_wact && mem_addr != p_addr) chk(0, "R7", 1, 0, "address moved during write");
    if (!wact && p_wact) begin
      chk(tnow - wr_start >= 55, "R5", tnow - wr_start, 55, "write pulse ns");
      chk(tnow - cs_start >= 60, "R5", tnow - cs_start, 60, "select to end ns");
      chk(tnow - addr_since >= 60, "R5", tnow - addr_since, 60, "address to end ns");
      chk(tnow - data_since >= 30, "R5", tnow - data_since, 30, "data setup ns");
      chk(dq_oe, "R6", dq_oe, 1, "data held at write end");
      mem[int'(wr_addr)] = dq_o;
    end
    p_sel = sel; p_rmode = rmode; p_wact = wact; p_addr = mem_addr; p_dq = dq_o;
  endtask

  initial begin
    #0.5;
    forever begin tick(); #1; tnow++; end
  end

  // bus rule monitors
  int r10_viol = 0;
  int hi_cnt = 1000;
  logic p_dq_oe = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((!mem_oe_n && !mem_we_n) || (dq_oe && !mem_oe_n)) r10_viol++;
      if (dq_oe && !p_dq_oe) chk(hi_cnt >= EXP_TA, "R8", hi_cnt, EXP_TA, "cycles oe high before drive");
      hi_cnt  = mem_oe_n ? hi_cnt + 1 : 0;
      p_dq_oe = dq_oe;
    end
  end

  task automatic access(input bit w, input logic [18:0] a, input logic [7:0] d, input bit poke,
                        input logic [18:0] pa);
    int n, lo;
    bit addr_ok, data_ok, hold_ok, saw_rise, pw;
    logic [7:0] expv;
    while (!ready) @(negedge clk);
    expv = shadow_rd(a);
    req = 1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    chk(!ready, "R11", ready, 0, "ready after accept");
    req = 0; addr = 19'($urandom); wdata = 8'($urandom);
    n = 0; lo = 0; addr_ok = 1; data_ok = 1; hold_ok = 0; saw_rise = 0; pw = 1;
    while (!ready && n < 100) begin
      if (w ? !mem_we_n : !mem_oe_n) lo++;
      if (!mem_cs_n && mem_addr != a) addr_ok = 0;
      if (dq_oe && dq_o != d) data_ok = 0;
      if (w && !pw && mem_we_n) begin saw_rise = 1; hold_ok = dq_oe && !mem_cs_n && mem_cs; end
      pw = mem_we_n;
      if (poke && n == 3) begin req = 1; wr = 1; addr = pa; wdata = ~d; end
      if (poke && n == 6) req = 0;
      @(negedge clk);
      n++;
    end
    if (w) begin
      chk(n == EXP_WP + 1, poke ? "R9" : "R4", n, EXP_WP + 1, "write latency");
      chk(lo == EXP_WP, "R5", lo, EXP_WP, "we low cycles");
      chk(data_ok, "R7", data_ok, 1, "write data held");
      chk(hold_ok && saw_rise, "R6", hold_ok, 1, "we rises before release");
      shadow[int'(a)] = d;
    end else begin
      chk(n == EXP_RD + EXP_TA, "R4", n, EXP_RD + EXP_TA, "read latency");
      chk(lo == EXP_RD, "R3", lo, EXP_RD, "oe low cycles");
      chk(rdata == expv, "R3", rdata, expv, "read data");
    end
    chk(addr_ok, "R7", addr_ok, 1, "address held");
    chk(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !dq_oe, "R2", mem_cs_n, 1, "deselected at ready");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd1234567));
    repeat (3) @(negedge clk);
    chk(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !dq_oe && ready, "R1",
        {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, dq_oe, ready}, 6'b101101, "reset pins");
    rst_n = 1;
    repeat (3) begin
      @(negedge clk);
      chk(ready && mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !dq_oe, "R2", ready, 1, "idle pins");
    end
    access(1, 19'h00000, 8'hFF, 0, '0);
    access(1, 19'h7FFFF, 8'h00, 0, '0);
    access(0, 19'h00000, 8'h00, 0, '0);
    access(0, 19'h7FFFF, 8'h00, 0, '0);
    access(0, 19'h12345, 8'h00, 0, '0);       // read straight into write: R8
    access(1, 19'h12346, 8'hC3, 0, '0);
    access(0, 19'h12346, 8'h00, 0, '0);       // write straight into read
    access(1, 19'h00100, 8'h9E, 1, 19'h00200); // R9 request while busy
    access(0, 19'h00200, 8'h00, 0, '0);
    access(0, 19'h00100, 8'h00, 0, '0);
    for (int i = 0; i < 80; i++) begin
      logic [18:0] a;
      a = {16'h0, 3'($urandom_range(0, 7))} ^ 19'h2A5A0;
      access(1'($urandom), a, 8'($urandom), 0, '0);
    end
    repeat (10) @(negedge clk);
    chk(r10_viol == 0, "R10", r10_viol, 0, "strobe exclusion violations");
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1, "run did not finish");
    finish_run();
  end

endmodule